// File: doc/BRIEF.md
# Maskable Interrupt Capture Controller

This block gathers single-cycle event pulses from the surrounding logic into sticky latches and turns them into one interrupt line toward a CPU. Five event sources are implemented. Each latch is set on the rising edge of its input. Software sees the latches through two windows. The capture window shows only the events that the enable register lets through, and a one written to it clears that event. The raw window shows every latched event whatever the enable bits say, and a one written to it sets that event, so software can raise an interrupt for testing.

A second output, the error line, is driven only by the three error-class events: the zero-length PDU event, the scheduler NIL-address event and the buffer-reader NIL-address event. The bus side is a plain strobe interface. A read returns its data on the cycle after the read strobe, flagged by a valid bit.

Top module: `irq_capture_ctrl`

## Requirements
- R1: After reset every event latch and every enable bit is 0, `irqOut` and `errIrqOut` are 0, and a read of any of the three registers returns 0.
- R2: Events are implemented on bits 19 (zero-length PDU), 18 (scheduler NIL address), 16 (buffer-reader NIL address), 1 (timeout) and 0 (raw-transmit done). A latch is set only on a 0-to-1 transition of its `evtIn` bit. An input that stays high does not set the latch again after it has been cleared. Pulses on any other bit are ignored and read as 0.
- R3: A read at byte offset 0x80 (capture) returns the event latches ANDed with the enable register.
- R4: A write at offset 0x80 clears every latch whose write-data bit is 1 and leaves the latches whose write-data bit is 0 unchanged.
- R5: A read at offset 0x84 (raw) returns the latches without masking. A write at 0x84 sets every implemented latch whose write-data bit is 1.
- R6: Offset 0x88 holds the enable register. It is written and read back directly, and only the implemented bits (mask 0x000D0003) can be stored.
- R7: `irqOut` is the OR of the masked latches, registered, so it changes one cycle after a latch or enable change takes effect. An event that is disabled never raises it.
- R8: `errIrqOut` is the registered OR of the masked latches on bits 19, 18 and 16 only. It is never high while `irqOut` is low.
- R9: If a rising event and a capture-write acknowledge hit the same bit in the same cycle, the latch ends up set.
- R10: `rdData` and `rdValid` are registered. They appear one cycle after `rdEn`, and a read of an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evtIn | input | 32 | Event inputs, each latched on its rising edge |
| addr | input | 8 | Byte offset for a read or write |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read strobe |
| rdData | output | 32 | Read data, valid when rdValid is 1 |
| rdValid | output | 1 | Read data valid, one cycle after rdEn |
| irqOut | output | 1 | Interrupt line, registered OR of the masked events |
| errIrqOut | output | 1 | Error interrupt line, driven by bits 19, 18 and 16 only |

## Verification
Two functions can act on the same latch bit in one cycle: a rising edge on an event input, and a capture-register write that acknowledges that bit. The bench provokes this by raising `evtIn` bit 19 in the same cycle as a capture write with bit 19 set. It then reads the raw window and expects the bit still set. In a second variant the rise lands on bit 1 while bit 0 is acknowledged, and the bench expects bit 0 to clear and bit 1 to be set. A third variant drives an acknowledge while an input is held high, to show that a level which does not change never re-arms its latch.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CAP  = 2'd1,
    SEL_RAW  = 2'd2,
    SEL_EN   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    capWr;
    logic    rawWr;
    logic    enWr;
    logic    rdReq;
    regSel_e sel;
  } irqStrobe_t;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CAP_OFS = 8'h80,
  parameter logic [ADDR_W-1:0] RAW_OFS = 8'h84,
  parameter logic [ADDR_W-1:0] EN_OFS  = 8'h88
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output irqStrobe_t        strb,
  output logic              rdValid
);
  regSel_e selDec;

  always_comb begin
    if (addr == CAP_OFS)      selDec = SEL_CAP;
    else if (addr == RAW_OFS) selDec = SEL_RAW;
    else if (addr == EN_OFS)  selDec = SEL_EN;
    else                      selDec = SEL_NONE;
  end

  always_comb begin
    strb.sel   = selDec;
    strb.capWr = wrEn && (selDec == SEL_CAP);
    strb.rawWr = wrEn && (selDec == SEL_RAW);
    strb.enWr  = wrEn && (selDec == SEL_EN);
    strb.rdReq = rdEn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdValid <= 1'b0;
    else        rdValid <= rdEn;
  end

  // R10: at most one write strobe per cycle, valid follows the read strobe
  a_r10_one_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.capWr, strb.rawWr, strb.enWr}));
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rdEn |=> rdValid);
endmodule

// File: rtl/irqc_dpath.sv
module irqc_dpath
  import irqc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] IMPL_MASK = 32'h000D_0003,
  parameter logic [DATA_W-1:0] ERR_MASK  = 32'h000D_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] evtIn,
  input  logic [DATA_W-1:0] wrData,
  input  irqStrobe_t        strb,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              errIrqOut
);
  logic [DATA_W-1:0] evtPrev;
  logic [DATA_W-1:0] rise;
  logic [DATA_W-1:0] setVec;
  logic [DATA_W-1:0] clrVec;
  logic [DATA_W-1:0] latch;
  logic [DATA_W-1:0] enReg;
  logic [DATA_W-1:0] masked;

  always_ff @(posedge clk) begin
    if (!rst_n) evtPrev <= '0;
    else        evtPrev <= evtIn;
  end

  assign rise   = evtIn & ~evtPrev;
  assign setVec = rise | (strb.rawWr ? wrData : '0);
  assign clrVec = strb.capWr ? wrData : '0;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_impl
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          latch[i] <= 1'b0;
          enReg[i] <= 1'b0;
        end else begin
          if (setVec[i])      latch[i] <= 1'b1;
          else if (clrVec[i]) latch[i] <= 1'b0;
          if (strb.enWr)      enReg[i] <= wrData[i];
        end
      end
    end else begin : g_tie
      assign latch[i] = 1'b0;
      assign enReg[i] = 1'b0;
    end
  end

  assign masked = latch & enReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irqOut    <= 1'b0;
      errIrqOut <= 1'b0;
      rdData    <= '0;
    end else begin
      irqOut    <= |masked;
      errIrqOut <= |(masked & ERR_MASK);
      if (strb.rdReq) begin
        case (strb.sel)
          SEL_CAP: rdData <= masked;
          SEL_RAW: rdData <= latch;
          SEL_EN:  rdData <= enReg;
          default: rdData <= '0;
        endcase
      end
    end
  end

  // R9: a rising implemented event is always latched, even against an acknowledge
  a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    |(rise & IMPL_MASK) |=> ((latch & $past(rise & IMPL_MASK)) == $past(rise & IMPL_MASK)));
  // R4: acknowledged bits without a new rise are clear next cycle
  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    strb.capWr |=> ((latch & $past(wrData & ~rise)) == '0));
  // R7: nothing masked in means the line is low next cycle
  a_r7_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (masked == '0) |=> !irqOut);
  // R8: the error line never stands alone
  a_r8_err_implies_irq: assert property (@(posedge clk) disable iff (!rst_n)
    errIrqOut |-> irqOut);
endmodule

// File: rtl/irq_capture_ctrl.sv
module irq_capture_ctrl
  import irqc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter logic [DATA_W-1:0] IMPL_MASK = 32'h000D_0003,
  parameter logic [DATA_W-1:0] ERR_MASK  = 32'h000D_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] evtIn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              irqOut,
  output logic              errIrqOut
);
  irqStrobe_t strb;

  irqc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .strb(strb), .rdValid(rdValid)
  );

  irqc_dpath #(.DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK), .ERR_MASK(ERR_MASK)) u_dpath (
    .clk(clk), .rst_n(rst_n), .evtIn(evtIn), .wrData(wrData), .strb(strb),
    .rdData(rdData), .irqOut(irqOut), .errIrqOut(errIrqOut)
  );
endmodule

// File: tb/sim_irq_capture_ctrl.sv
`timescale 1ns/1ps
module sim_irq_capture_ctrl;
  localparam logic [31:0] IMPL = 32'h000D_0003;
  localparam logic [31:0] ERRM = 32'h000D_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evtIn = '0;
  logic [7:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;
  logic        rdValid;
  logic        irqOut;
  logic        errIrqOut;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 1'b0;
  logic [31:0] mLatch = '0;
  logic [31:0] mEn = '0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  irq_capture_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .evtIn(evtIn), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .rdValid(rdValid),
    .irqOut(irqOut), .errIrqOut(errIrqOut)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data whenever the design flags a result
  always @(negedge clk) begin
    if (rst_n && rdValid) begin
      if (expQ.size() == 0) check("R10 unexpected rdValid", 32'h1, 32'h0);
      else check(tagQ.pop_front(), rdData, expQ.pop_front());
    end
  end

  task automatic busWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    if (a == 8'h80) mLatch = mLatch & ~d;
    else if (a == 8'h84) mLatch = mLatch | (d & IMPL);
    else if (a == 8'h88) mEn = d & IMPL;
  endtask

  task automatic busRead(logic [7:0] a, string tag);
    logic [31:0] e;
    @(negedge clk);
    if (a == 8'h80) e = mLatch & mEn;
    else if (a == 8'h84) e = mLatch;
    else if (a == 8'h88) e = mEn;
    else e = '0;
    expQ.push_back(e); tagQ.push_back(tag);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse(logic [31:0] bits);
    @(negedge clk);
    evtIn = bits;
    @(negedge clk);
    evtIn = '0;
    mLatch = mLatch | (bits & IMPL);
  endtask

  task automatic checkLines(string tag);
    @(negedge clk);
    check({tag, " irqOut"}, {31'd0, irqOut}, {31'd0, |(mLatch & mEn)});
    check({tag, " errIrqOut"}, {31'd0, errIrqOut}, {31'd0, |(mLatch & mEn & ERRM)});
  endtask

  task automatic finish();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    nErrors++; nChecks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    checkLines("R1");
    busRead(8'h80, "R1 capture after reset");
    busRead(8'h84, "R1 raw after reset");
    busRead(8'h88, "R1 enable after reset");
    // R6 only implemented enable bits stick
    busWrite(8'h88, 32'hFFFF_FFFF);
    busRead(8'h88, "R6 enable readback");
    // R2 R3 R7 single event
    pulse(32'h0000_0001);
    checkLines("R7 bit0 enabled");
    busRead(8'h80, "R3 capture bit0");
    // R7 mask it off: line falls, raw still shows it
    busWrite(8'h88, 32'h0000_0002);
    checkLines("R7 disabled event");
    busRead(8'h80, "R3 capture masked");
    busRead(8'h84, "R5 raw unmasked");
    // R4 acknowledge clears only the ones written
    busWrite(8'h84, 32'h0000_0002);
    busWrite(8'h80, 32'h0000_0001);
    busRead(8'h84, "R4 ack bit0 keeps bit1");
    // R5 software trigger with unimplemented bits
    busWrite(8'h84, 32'h00FF_00F3);
    busRead(8'h84, "R5 raw after trigger");
    busRead(8'h80, "R3 capture after trigger");
    checkLines("R7 trigger");
    busWrite(8'h80, 32'hFFFF_FFFF);
    busRead(8'h84, "R4 ack all");
    checkLines("R7 after ack all");
    // R8 error line only from error bits
    busWrite(8'h88, 32'h000D_0003);
    pulse(32'h0000_0002);
    checkLines("R8 non-error event");
    pulse(32'h0001_0000);
    checkLines("R8 error event bit16");
    busWrite(8'h80, 32'h0001_0000);
    checkLines("R8 error cleared");
    busWrite(8'h80, 32'h0000_0002);
    // R2 held input fires once, unimplemented bit ignored
    @(negedge clk); evtIn = 32'h0004_0000;
    @(negedge clk); mLatch = mLatch | 32'h0004_0000;
    busWrite(8'h80, 32'h0004_0000);
    repeat (2) @(negedge clk);
    busRead(8'h84, "R2 held input not re-armed");
    @(negedge clk); evtIn = '0;
    pulse(32'h0000_0020);
    busRead(8'h84, "R2 unimplemented bit ignored");
    checkLines("R2 lines quiet");
    // R9 new event beats acknowledge on the same bit
    busWrite(8'h84, 32'h0000_0001);
    @(negedge clk);
    evtIn = 32'h0008_0000; addr = 8'h80; wrData = 32'h0008_0001; wrEn = 1'b1;
    @(negedge clk);
    evtIn = '0; wrEn = 1'b0;
    mLatch = (mLatch & ~32'h0008_0001) | 32'h0008_0000;
    busRead(8'h84, "R9 same-bit rise wins");
    busWrite(8'h80, 32'hFFFF_FFFF);
    busWrite(8'h84, 32'h0000_0001);
    @(negedge clk);
    evtIn = 32'h0000_0002; addr = 8'h80; wrData = 32'h0000_0001; wrEn = 1'b1;
    @(negedge clk);
    evtIn = '0; wrEn = 1'b0;
    mLatch = 32'h0000_0002;
    busRead(8'h84, "R9 rise on other bit");
    checkLines("R9 lines");
    // R10 unmapped read returns zero
    busRead(8'h90, "R10 unmapped read");
    busRead(8'h00, "R10 unmapped read low");
    repeat (3) @(negedge clk);
    check("R10 pending reads", expQ.size(), 0);
    finish();
  end
endmodule